// File: doc/BRIEF.md
# Genlock Reference-Loss Mode Controller

This controller sequences the operating mode of a video clock generator. In free-run mode the clock runs on its own. In genlock mode the controller watches one of two reference ports. Each port carries a horizontal and a vertical sync. The controller decides whether the chosen reference is usable and steps through acquisition and lock. It also handles what happens when the reference goes away.

The controller counts reference clocks between horizontal sync rising edges and compares the count with a programmed expected line length. It declares the reference lost in three cases: horizontal edges stop arriving, vertical sync goes missing, or the line length leaves the tolerance band too often. Once the reference is lost, a configuration bit picks one of two states. One is free running. The other is holdover, in which the loop-filter output is tri-stated so the control voltage is held. The reference counts as back once enough good lines have been seen, and the controller then goes straight to acquiring lock. The analog loop appears only as a lock-indication input.

Top module: `genlock_ref_ctrl`

## Requirements
- R1: While `cfg_genlock` is 0, the controller is in free run one clock later, whatever the reference and lock inputs do. In free run the flags are `flag_no_ref`=0, `flag_no_lock`=1 and `lpf_hiz_en`=0.
- R2: In genlock mode with `cfg_hold`=0, loss of reference leads to the reference-lost free-run state. Its outputs are `flag_no_ref`=1, `flag_no_lock`=1 and `lpf_hiz_en`=0.
- R3: In genlock mode with `cfg_hold`=1, loss of reference leads to holdover. Its outputs are `flag_no_ref`=1, `flag_no_lock`=1 and `lpf_hiz_en`=1, all in the first cycle of that state.
- R4: `lpf_hiz_en` is 1 only in holdover, and it drops in the same cycle the controller leaves holdover.
- R5: The reference counts as valid again after `GOOD_LINES` (8) consecutive in-tolerance line periods. From either reference-lost state the controller then enters acquire on the next clock, which shows as `flag_no_ref`=0, `flag_no_lock`=1.
- R6: `cfg_port_b`=0 selects port A and 1 selects port B. Sync activity on the port that is not selected has no effect.
- R7: If no horizontal rising edge arrives within 2×`cfg_h_expect` clocks of the previous one, the reference is lost.
- R8: A line is bad when its measured period (clocks between horizontal rising edges) differs from `cfg_h_expect` by more than `cfg_h_tol`+1. `BAD_LINES` (4) consecutive bad lines make a valid reference lost, and a good line in between restarts that count.
- R9: In acquire, `pll_lock_in` held high for `LOCK_CYC` (16) consecutive clocks moves the controller to locked (`flag_no_ref`=0, `flag_no_lock`=0). If `pll_lock_in` drops while locked, the controller returns to acquire.
- R10: If `MAX_LINES` horizontal edges pass without a vertical sync rising edge, the reference is lost. It cannot become valid again until a vertical sync edge arrives.
- R11: After reset the controller is in free run (`flag_no_ref`=0, `flag_no_lock`=1, `lpf_hiz_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_genlock | input | 1 | 1 = genlock mode, 0 = free-run mode |
| cfg_hold | input | 1 | 1 = holdover on reference loss, 0 = free run on reference loss |
| cfg_port_b | input | 1 | Reference port select, 0 = A, 1 = B |
| cfg_h_expect | input | CNT_W | Expected line period in clocks |
| cfg_h_tol | input | ERR_W | Line period tolerance setting, 0 is tightest |
| ref_a_hsync | input | 1 | Port A horizontal sync |
| ref_a_vsync | input | 1 | Port A vertical sync |
| ref_b_hsync | input | 1 | Port B horizontal sync |
| ref_b_vsync | input | 1 | Port B vertical sync |
| pll_lock_in | input | 1 | Lock indication from the analog loop |
| lpf_hiz_en | output | 1 | Loop-filter output tri-state enable |
| flag_no_ref | output | 1 | Reference-absent status |
| flag_no_lock | output | 1 | Not-locked status |

## Verification
A wrong state shows at once on the three outputs, since each state has its own fixed combination of flags and tri-state enable. Acquire and free run share the same combination. They are told apart by when the controller enters locked and by the mode input. A fault in the line measurement or in the run counters shows as a state change one clock early or late, after the horizontal edge that completes a run. A fault in the lock filter moves the entry into locked away from the sixteenth stable clock. The bench models the controller behaviourally and compares all three outputs on every clock, so any of these faults is caught in the first cycle it differs.

// File: rtl/gnlk_pkg.sv
package gnlk_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_LOCK = 3'd2,
    ST_HOLD = 3'd3,
    ST_LORF = 3'd4
  } gnlk_state_t;
endpackage

// File: rtl/gnlk_port_sel.sv
module gnlk_port_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  input  logic hs_a,
  input  logic vs_a,
  input  logic hs_b,
  input  logic vs_b,
  output logic hs_rise,
  output logic vs_rise
);
  localparam int NSIG = 2;
  logic [NSIG-1:0] sig_sel;
  logic [NSIG-1:0] sig_q;
  logic [NSIG-1:0] sig_rise;

  assign sig_sel = sel_b ? {vs_b, hs_b} : {vs_a, hs_a};

  for (genvar g = 0; g < NSIG; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q[g] <= 1'b0;
      else        sig_q[g] <= sig_sel[g];
    end
    assign sig_rise[g] = sig_sel[g] & ~sig_q[g];
  end

  assign hs_rise = sig_rise[0];
  assign vs_rise = sig_rise[1];
endmodule

// File: rtl/gnlk_hmeas.sv
module gnlk_hmeas #(
  parameter int CNT_W     = 12,
  parameter int ERR_W     = 4,
  parameter int MAX_LINES = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic [CNT_W-1:0] exp_per,
  input  logic [ERR_W-1:0] tol,
  output logic             line_good,
  output logic             line_bad,
  output logic             hs_tmo,
  output logic             vs_fault
);
  localparam int LW = $clog2(MAX_LINES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [LW-1:0] LINES_LIM = LW'(MAX_LINES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             have_q, have_d;
  logic             tmo_q, tmo_d;
  logic [LW-1:0]    lines_q, lines_d;
  logic [CNT_W:0]   per, exp_x, diff, thr;
  logic             verdict;

  assign per     = {1'b0, cnt_q} + 1'b1;
  assign exp_x   = {1'b0, exp_per};
  assign diff    = (per > exp_x) ? (per - exp_x) : (exp_x - per);
  assign thr     = {{(CNT_W + 1 - ERR_W){1'b0}}, tol} + 1'b1;
  assign verdict = hs_rise & have_q & ~tmo_q;

  assign line_good = verdict & (diff <= thr);
  assign line_bad  = verdict & (diff > thr);
  assign hs_tmo    = ~hs_rise & have_q & ~tmo_q & (per >= {exp_per, 1'b0});
  assign vs_fault  = (lines_q == LINES_LIM);

  always_comb begin
    cnt_d   = cnt_q;
    have_d  = have_q;
    tmo_d   = tmo_q;
    lines_d = lines_q;
    if (hs_rise) begin
      cnt_d  = '0;
      have_d = 1'b1;
      tmo_d  = 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (hs_tmo) tmo_d = 1'b1;
    end
    if (vs_rise) lines_d = '0;
    else if (hs_rise && !vs_fault) lines_d = lines_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      have_q  <= 1'b0;
      tmo_q   <= 1'b0;
      lines_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      have_q  <= have_d;
      tmo_q   <= tmo_d;
      lines_q <= lines_d;
    end
  end

  // R7: a timeout is reported once, then held off until the next edge
  assert_tmo_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_tmo |=> !hs_tmo);
  // R8: a line cannot be judged good and bad together
  assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_good && line_bad));
endmodule

// File: rtl/gnlk_lor_det.sv
module gnlk_lor_det #(
  parameter int GOOD_LINES = 8,
  parameter int BAD_LINES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_good,
  input  logic line_bad,
  input  logic hs_tmo,
  input  logic vs_fault,
  output logic ref_ok
);
  localparam int GW = $clog2(GOOD_LINES) + 1;
  localparam int BW = $clog2(BAD_LINES) + 1;
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_LINES - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_LINES - 1);

  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          ok_q, ok_d;

  always_comb begin
    good_d = good_q;
    bad_d  = bad_q;
    ok_d   = ok_q;
    if (hs_tmo || vs_fault) begin
      ok_d   = 1'b0;
      good_d = '0;
      bad_d  = '0;
    end else if (line_good) begin
      bad_d = '0;
      if (ok_q) good_d = '0;
      else if (good_q == GOOD_LAST) begin
        ok_d   = 1'b1;
        good_d = '0;
      end else good_d = good_q + 1'b1;
    end else if (line_bad) begin
      good_d = '0;
      if (!ok_q) bad_d = '0;
      else if (bad_q == BAD_LAST) begin
        ok_d  = 1'b0;
        bad_d = '0;
      end else bad_d = bad_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      good_q <= good_d;
      bad_q  <= bad_d;
      ok_q   <= ok_d;
    end
  end

  assign ref_ok = ok_q;

  // R7 / R10: a timeout or missing vertical sync invalidates the reference
  assert_tmo_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_tmo || vs_fault) |=> !ref_ok);
  // R10: no recovery while vertical sync is missing
  assert_no_rise_vsfault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vs_fault |=> !$rose(ref_ok));
  // R8: a single bad line never drops a reference that was valid for a while
  assert_bad_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && $past(ref_ok) && line_bad && !hs_tmo && !vs_fault && bad_q == '0) |=> ref_ok);
endmodule

// File: rtl/gnlk_lock_filt.sv
module gnlk_lock_filt #(
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  output logic lock_ok
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LIM = LW'(LOCK_CYC);

  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!lock_in)        cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lock_ok = (cnt_q == LIM);

  // R9: lock qualification is lost one clock after the input drops
  assert_lock_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> !lock_ok);
endmodule

// File: rtl/genlock_ref_ctrl.sv
module genlock_ref_ctrl #(
  parameter int CNT_W      = 12,
  parameter int ERR_W      = 4,
  parameter int MAX_LINES  = 1200,
  parameter int GOOD_LINES = 8,
  parameter int BAD_LINES  = 4,
  parameter int LOCK_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_genlock,
  input  logic             cfg_hold,
  input  logic             cfg_port_b,
  input  logic [CNT_W-1:0] cfg_h_expect,
  input  logic [ERR_W-1:0] cfg_h_tol,
  input  logic             ref_a_hsync,
  input  logic             ref_a_vsync,
  input  logic             ref_b_hsync,
  input  logic             ref_b_vsync,
  input  logic             pll_lock_in,
  output logic             lpf_hiz_en,
  output logic             flag_no_ref,
  output logic             flag_no_lock
);
  import gnlk_pkg::*;

  logic [1:0] rs_q;
  logic       rst_i;
  logic       hs_rise, vs_rise;
  logic       line_good, line_bad, hs_tmo, vs_fault;
  logic       ref_ok, lock_ok;
  gnlk_state_t state_q, state_d, lor_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  gnlk_port_sel u_sel (
    .clk(clk), .rst_n(rst_i), .sel_b(cfg_port_b),
    .hs_a(ref_a_hsync), .vs_a(ref_a_vsync),
    .hs_b(ref_b_hsync), .vs_b(ref_b_vsync),
    .hs_rise(hs_rise), .vs_rise(vs_rise)
  );

  gnlk_hmeas #(.CNT_W(CNT_W), .ERR_W(ERR_W), .MAX_LINES(MAX_LINES)) u_meas (
    .clk(clk), .rst_n(rst_i), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .exp_per(cfg_h_expect), .tol(cfg_h_tol),
    .line_good(line_good), .line_bad(line_bad),
    .hs_tmo(hs_tmo), .vs_fault(vs_fault)
  );

  gnlk_lor_det #(.GOOD_LINES(GOOD_LINES), .BAD_LINES(BAD_LINES)) u_lor (
    .clk(clk), .rst_n(rst_i), .line_good(line_good), .line_bad(line_bad),
    .hs_tmo(hs_tmo), .vs_fault(vs_fault), .ref_ok(ref_ok)
  );

  gnlk_lock_filt #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_i), .lock_in(pll_lock_in), .lock_ok(lock_ok)
  );

  assign lor_tgt = cfg_hold ? ST_HOLD : ST_LORF;

  always_comb begin
    state_d = state_q;
    if (!cfg_genlock) begin
      state_d = ST_FREE;
    end else begin
      unique case (state_q)
        ST_FREE, ST_HOLD, ST_LORF: state_d = ref_ok ? ST_ACQ : lor_tgt;
        ST_ACQ:  state_d = !ref_ok ? lor_tgt : (lock_ok ? ST_LOCK : ST_ACQ);
        ST_LOCK: state_d = !ref_ok ? lor_tgt : (lock_ok ? ST_LOCK : ST_ACQ);
        default: state_d = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) state_q <= ST_FREE;
    else        state_q <= state_d;
  end

  assign lpf_hiz_en   = (state_q == ST_HOLD);
  assign flag_no_ref  = (state_q == ST_HOLD) || (state_q == ST_LORF);
  assign flag_no_lock = (state_q != ST_LOCK);

  // R1: free-run mode forces the free state one clock later
  assert_freerun_mode_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_genlock |=> (state_q == ST_FREE));
  // R3: reference loss with holdover selected tri-states the loop filter next clock
  assert_hold_entry_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_genlock && cfg_hold && !ref_ok && state_q == ST_LOCK) |=> lpf_hiz_en);
  // R5: a returning reference is acted on without delay
  assert_return_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_genlock && ref_ok && flag_no_ref) |=> (state_q == ST_ACQ));
  // R9: locked is only entered with a qualified lock indication
  assert_lock_entry_R9: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(state_q == ST_LOCK) |-> $past(lock_ok));
endmodule

// File: tb/genlock_ref_ctrl_test.sv
`timescale 1ns/1ps
module genlock_ref_ctrl_test;
  localparam int CNT_W = 12;
  localparam int ERR_W = 4;
  localparam int MAXL  = 16;
  localparam int EXPP  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_genlock = 1'b0, cfg_hold = 1'b0, cfg_port_b = 1'b0;
  logic [CNT_W-1:0] cfg_h_expect = CNT_W'(EXPP);
  logic [ERR_W-1:0] cfg_h_tol = '0;
  logic a_hs = 1'b0, a_vs = 1'b0, b_hs = 1'b0, b_vs = 1'b0;
  logic pll_lock = 1'b0;
  logic lpf_hiz_en, flag_no_ref, flag_no_lock;

  int errors = 0, checks = 0, cyc = 0, line_idx = 0;
  bit vs_en = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  genlock_ref_ctrl #(.CNT_W(CNT_W), .ERR_W(ERR_W), .MAX_LINES(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_genlock(cfg_genlock), .cfg_hold(cfg_hold),
    .cfg_port_b(cfg_port_b), .cfg_h_expect(cfg_h_expect), .cfg_h_tol(cfg_h_tol),
    .ref_a_hsync(a_hs), .ref_a_vsync(a_vs), .ref_b_hsync(b_hs), .ref_b_vsync(b_vs),
    .pll_lock_in(pll_lock), .lpf_hiz_en(lpf_hiz_en),
    .flag_no_ref(flag_no_ref), .flag_no_lock(flag_no_lock)
  );

  // behavioural reference model: 0 free, 1 acquire, 2 locked, 3 holdover, 4 lost/free
  int m_rc, m_state, m_cnt, m_lines, m_good, m_bad, m_lk;
  bit m_have, m_tmo, m_ok, m_hsp, m_vsp;

  task automatic m_reset();
    m_state = 0; m_cnt = 0; m_lines = 0; m_good = 0; m_bad = 0; m_lk = 0;
    m_have = 0; m_tmo = 0; m_ok = 0; m_hsp = 0; m_vsp = 0;
  endtask

  task automatic m_step();
    bit hs, vs, hr, vr, g, b, to, vf, lok;
    int per, diff, nst, lost;
    hs = cfg_port_b ? b_hs : a_hs;
    vs = cfg_port_b ? b_vs : a_vs;
    hr = hs && !m_hsp;
    vr = vs && !m_vsp;
    per = m_cnt + 1;
    diff = (per > int'(cfg_h_expect)) ? per - int'(cfg_h_expect) : int'(cfg_h_expect) - per;
    g = hr && m_have && !m_tmo && (diff <= int'(cfg_h_tol) + 1);
    b = hr && m_have && !m_tmo && (diff > int'(cfg_h_tol) + 1);
    to = !hr && m_have && !m_tmo && (per >= 2 * int'(cfg_h_expect));
    vf = (m_lines == MAXL);
    lok = (m_lk == 16);
    lost = cfg_hold ? 3 : 4;
    if (!cfg_genlock) nst = 0;
    else if (!m_ok) nst = lost;
    else if (m_state == 1 || m_state == 2) nst = lok ? 2 : 1;
    else nst = 1;
    if (to || vf) begin m_ok = 0; m_good = 0; m_bad = 0; end
    else if (g) begin
      m_bad = 0;
      if (m_ok) m_good = 0;
      else if (m_good == 7) begin m_ok = 1; m_good = 0; end
      else m_good++;
    end else if (b) begin
      m_good = 0;
      if (!m_ok) m_bad = 0;
      else if (m_bad == 3) begin m_ok = 0; m_bad = 0; end
      else m_bad++;
    end
    if (hr) begin m_cnt = 0; m_have = 1; m_tmo = 0; end
    else begin
      if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
      if (to) m_tmo = 1;
    end
    if (vr) m_lines = 0;
    else if (hr && !vf) m_lines++;
    m_lk = pll_lock ? ((m_lk < 16) ? m_lk + 1 : 16) : 0;
    m_hsp = hs; m_vsp = vs;
    m_state = nst;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_rc = 0; m_reset(); end
    else if (m_rc < 2) begin m_rc++; m_reset(); end
    else m_step();
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    bit e_ref, e_lock, e_hiz;
    if (rst_n && !done) begin
      e_ref  = (m_state == 3 || m_state == 4);
      e_lock = (m_state != 2);
      e_hiz  = (m_state == 3);
      checks++;
      if (flag_no_ref !== e_ref || flag_no_lock !== e_lock || lpf_hiz_en !== e_hiz) begin
        errors++;
        $display("FAIL R2/R3/R4/R9 model cycle %0d: got ref=%b lock=%b hiz=%b exp ref=%b lock=%b hiz=%b",
                 cyc, flag_no_ref, flag_no_lock, lpf_hiz_en, e_ref, e_lock, e_hiz);
      end
    end
  end

  task automatic chk(input string req, input bit e_ref, input bit e_lock, input bit e_hiz);
    checks++;
    if (flag_no_ref !== e_ref || flag_no_lock !== e_lock || lpf_hiz_en !== e_hiz) begin
      errors++;
      $display("FAIL %s: got ref=%b lock=%b hiz=%b exp ref=%b lock=%b hiz=%b",
               req, flag_no_ref, flag_no_lock, lpf_hiz_en, e_ref, e_lock, e_hiz);
    end
  endtask

  task automatic lines(input int n, input int per, input bit onb);
    for (int k = 0; k < n; k++) begin
      bit v;
      v = vs_en && (line_idx % 8 == 0);
      line_idx++;
      for (int c = 0; c < per; c++) begin
        if (onb) begin b_hs = (c < 2); b_vs = v && (c < 2); end
        else     begin a_hs = (c < 2); a_vs = v && (c < 2); end
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pll_lock = 1'b1;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    chk("R11 reset state", 0, 1, 0);
    lines(12, EXPP, 0);
    chk("R1 free-run mode ignores reference", 0, 1, 0);
    cfg_genlock = 1'b1;
    lines(2, EXPP, 0);
    chk("R9 locked after stable lock", 0, 0, 0);
    pll_lock = 1'b0;
    idle(50);
    chk("R7 R2 timeout to lost free run", 1, 1, 0);
    lines(9, EXPP, 0);
    chk("R5 acquire after 8 good lines", 0, 1, 0);
    pll_lock = 1'b1;
    lines(1, EXPP, 0);
    chk("R9 lock qualified", 0, 0, 0);
    pll_lock = 1'b0;
    lines(1, EXPP, 0);
    chk("R9 lock drop back to acquire", 0, 1, 0);
    pll_lock = 1'b1;
    lines(1, EXPP, 0);
    cfg_hold = 1'b1;
    lines(3, EXPP + 3, 0);
    lines(2, EXPP, 0);
    chk("R8 three bad lines keep lock", 0, 0, 0);
    lines(4, EXPP + 2, 0);
    lines(1, EXPP, 0);
    chk("R3 R8 four bad lines to holdover", 1, 1, 1);
    lines(8, EXPP + 1, 0);
    chk("R4 R5 holdover released on return", 0, 0, 0);
    cfg_h_tol = ERR_W'(2);
    lines(5, EXPP + 3, 0);
    lines(1, EXPP, 0);
    chk("R8 wider tolerance accepts lines", 0, 0, 0);
    cfg_h_tol = '0;
    lines(10, EXPP, 1);
    chk("R6 unselected port ignored", 1, 1, 1);
    cfg_port_b = 1'b1;
    lines(9, EXPP, 1);
    chk("R6 port B selected", 0, 0, 0);
    vs_en = 1'b0;
    lines(20, EXPP, 1);
    chk("R10 missing vertical sync", 1, 1, 1);
    vs_en = 1'b1;
    line_idx = 0;
    lines(12, EXPP, 1);
    chk("R10 recovery after vertical sync", 0, 0, 0);
    cfg_genlock = 1'b0;
    lines(1, EXPP, 1);
    chk("R1 back to free-run mode", 0, 1, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule